// File: doc/BRIEF.md
# Absolute-to-Physical Address Space Mapper

This block takes an absolute address and produces the 64-bit physical address that the memory system sees. It sorts each address into one of three regions, main memory, I/O space or firmware space, by testing two 4-bit fields near the top of the active address width. Each region then has its upper physical bits rebuilt in its own way. A wide-mode input selects 64-bit absolute addressing, with the fields at bits 61:58 and 57:54. When it is low, 32-bit addressing applies, with the fields at bits 31:28 and 27:24. A legacy input overrides both modes and hands the address through untouched, for the older architecture level.

The decode is purely combinational and feeds one register stage. The stage carries a valid flag, so a caller presents an address with `in_valid` and collects the mapped address and its region code one clock later. Virtual translation, protection checks and the TLB sit outside this block.

Top module: `abs_map_top`

## Requirements
- R1: With wide_mode=1 and legacy_mode=0, an address whose bits 61:58 are not 4'hF is memory (region code 0), and phys_addr is the address with bits 63:62 cleared.
- R2: With wide_mode=1 and legacy_mode=0, bits 61:58 equal to 4'hF and bits 57:54 nonzero give I/O (region code 1), and phys_addr is the address with bits 63:62 set.
- R3: With wide_mode=1 and legacy_mode=0, bits 61:58 equal to 4'hF and bits 57:54 zero give firmware (region code 2), and phys_addr holds address bits 53:0, zeros in 59:54 and ones in 63:60.
- R4: With wide_mode=0 and legacy_mode=0, an address whose bits 31:28 are not 4'hF is memory (region code 0), and phys_addr is address bits 31:0 zero-extended. Input bits 63:32 have no effect.
- R5: With wide_mode=0 and legacy_mode=0, bits 31:28 equal to 4'hF and bits 27:24 nonzero give I/O (region code 1), and phys_addr is address bits 31:0 with bits 63:32 all ones.
- R6: With wide_mode=0 and legacy_mode=0, bits 31:28 equal to 4'hF and bits 27:24 zero give firmware (region code 2), and phys_addr holds address bits 23:0, zeros in 59:24 and ones in 63:60.
- R7: With legacy_mode=1, phys_addr equals the address unchanged and the region code is 0, whatever wide_mode is.
- R8: out_valid equals in_valid from the previous clock. phys_addr and region load the mapping of the address presented with in_valid=1 and hold their values while in_valid=0.
- R9: A synchronous reset clears out_valid, phys_addr and region to zero on the next clock, even when in_valid is high. Region code 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Address presented this cycle |
| abs_addr | input | 64 | Absolute address to map |
| wide_mode | input | 1 | 1 selects 64-bit addressing, 0 selects 32-bit |
| legacy_mode | input | 1 | 1 passes the address through unchanged |
| out_valid | output | 1 | Registered result valid |
| phys_addr | output | 64 | Registered physical address |
| region | output | 2 | Registered region: 0 memory, 1 I/O, 2 firmware |

## Verification
Two pairs of controls can land in the same cycle. The first pair is legacy_mode and wide_mode. The bench raises both together on firmware-pattern and I/O-pattern addresses and requires an exact pass-through, so legacy must win over the wide decode. The second pair is reset and a valid input. The bench presents an address with in_valid high while reset is asserted and requires zeroed outputs one clock later. The idle cycles that follow check that nothing reloads until the next valid input.

// File: rtl/abs_map_pkg.sv
package abs_map_pkg;

  parameter int NIB_W = 4;

  typedef enum logic [1:0] {
    RG_MEM = 2'd0,
    RG_IO  = 2'd1,
    RG_FW  = 2'd2
  } region_e;

  // A selector field of all ones opens the special window; the sub field picks I/O or firmware.
  function automatic region_e classify(input logic [NIB_W-1:0] sel_f,
                                       input logic [NIB_W-1:0] sub_f);
    if (sel_f != {NIB_W{1'b1}})
      return RG_MEM;
    else if (sub_f != '0)
      return RG_IO;
    else
      return RG_FW;
  endfunction

endpackage

// File: rtl/abs_map_classify.sv
module abs_map_classify
  import abs_map_pkg::*;
(
  input  logic             wide_mode,
  input  logic [NIB_W-1:0] wide_sel,
  input  logic [NIB_W-1:0] wide_sub,
  input  logic [NIB_W-1:0] nar_sel,
  input  logic [NIB_W-1:0] nar_sub,
  output region_e          region
);

  logic [NIB_W-1:0] sel_f;
  logic [NIB_W-1:0] sub_f;

  always_comb begin
    sel_f  = wide_mode ? wide_sel : nar_sel;
    sub_f  = wide_mode ? wide_sub : nar_sub;
    region = classify(sel_f, sub_f);
  end

endmodule

// File: rtl/abs_map_rebuild.sv
module abs_map_rebuild
  import abs_map_pkg::*;
#(
  parameter int ADDR_W         = 64,
  parameter int NARROW_W       = 32,
  parameter int WIDE_SEL_LSB   = 58,
  parameter int WIDE_SUB_LSB   = 54,
  parameter int NARROW_SUB_LSB = 24,
  parameter int FW_TAG_LSB     = 60
) (
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic              wide_mode,
  input  logic              legacy_mode,
  input  region_e           region,
  output logic [ADDR_W-1:0] phys_addr
);

  localparam logic [ADDR_W-1:0] ONES        = {ADDR_W{1'b1}};
  localparam int                WIDE_UP_LSB = WIDE_SEL_LSB + NIB_W;
  localparam logic [ADDR_W-1:0] WIDE_UP     = ONES << WIDE_UP_LSB;
  localparam logic [ADDR_W-1:0] WIDE_FW_KEEP = ONES >> (ADDR_W - WIDE_SUB_LSB);
  localparam logic [ADDR_W-1:0] FW_TAG      = ONES << FW_TAG_LSB;
  localparam logic [ADDR_W-1:0] NAR_KEEP    = ONES >> (ADDR_W - NARROW_W);
  localparam logic [ADDR_W-1:0] NAR_FW_KEEP = ONES >> (ADDR_W - NARROW_SUB_LSB);

  function automatic logic [ADDR_W-1:0] map_wide(input logic [ADDR_W-1:0] a,
                                                 input region_e r);
    case (r)
      RG_IO:   return a | WIDE_UP;
      RG_FW:   return (a & WIDE_FW_KEEP) | FW_TAG;
      default: return a & ~WIDE_UP;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] map_narrow(input logic [ADDR_W-1:0] a,
                                                   input region_e r);
    case (r)
      RG_IO:   return (a & NAR_KEEP) | ~NAR_KEEP;
      RG_FW:   return (a & NAR_FW_KEEP) | FW_TAG;
      default: return a & NAR_KEEP;
    endcase
  endfunction

  always_comb begin
    if (legacy_mode)
      phys_addr = abs_addr;
    else if (wide_mode)
      phys_addr = map_wide(abs_addr, region);
    else
      phys_addr = map_narrow(abs_addr, region);
  end

endmodule

// File: rtl/abs_map_outreg.sv
module abs_map_outreg
  import abs_map_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] d_addr,
  input  region_e           d_region,
  output logic              out_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [1:0]        region
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      phys_addr <= '0;
      region    <= RG_MEM;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        phys_addr <= d_addr;
        region    <= d_region;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(phys_addr) && $stable(region))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && phys_addr == '0 && region == 2'd0)); // R9
  AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (rst)
    region != 2'd3); // R9

endmodule

// File: rtl/abs_map_top.sv
module abs_map_top
  import abs_map_pkg::*;
#(
  parameter int ADDR_W         = 64,
  parameter int NARROW_W       = 32,
  parameter int WIDE_SEL_LSB   = 58,
  parameter int WIDE_SUB_LSB   = 54,
  parameter int NARROW_SEL_LSB = 28,
  parameter int NARROW_SUB_LSB = 24,
  parameter int FW_TAG_LSB     = 60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic              wide_mode,
  input  logic              legacy_mode,
  output logic              out_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic [1:0]        region
);

  localparam int WIDE_UP_LSB = WIDE_SEL_LSB + NIB_W;
  localparam int FW_TAG_W    = ADDR_W - FW_TAG_LSB;
  localparam int NAR_UP_W    = ADDR_W - NARROW_W;

  region_e           cls_region_w;
  region_e           next_region_w;
  logic [ADDR_W-1:0] next_addr_w;
  logic              is_io_w;
  logic              is_fw_w;
  logic              is_mem_w;

  abs_map_classify u_classify (
    .wide_mode (wide_mode),
    .wide_sel  (abs_addr[WIDE_SEL_LSB +: NIB_W]),
    .wide_sub  (abs_addr[WIDE_SUB_LSB +: NIB_W]),
    .nar_sel   (abs_addr[NARROW_SEL_LSB +: NIB_W]),
    .nar_sub   (abs_addr[NARROW_SUB_LSB +: NIB_W]),
    .region    (cls_region_w)
  );

  abs_map_rebuild #(
    .ADDR_W         (ADDR_W),
    .NARROW_W       (NARROW_W),
    .WIDE_SEL_LSB   (WIDE_SEL_LSB),
    .WIDE_SUB_LSB   (WIDE_SUB_LSB),
    .NARROW_SUB_LSB (NARROW_SUB_LSB),
    .FW_TAG_LSB     (FW_TAG_LSB)
  ) u_rebuild (
    .abs_addr    (abs_addr),
    .wide_mode   (wide_mode),
    .legacy_mode (legacy_mode),
    .region      (cls_region_w),
    .phys_addr   (next_addr_w)
  );

  assign next_region_w = legacy_mode ? RG_MEM : cls_region_w;
  assign is_io_w  = !legacy_mode && (cls_region_w == RG_IO);
  assign is_fw_w  = !legacy_mode && (cls_region_w == RG_FW);
  assign is_mem_w = !legacy_mode && (cls_region_w == RG_MEM);

  abs_map_outreg #(
    .ADDR_W (ADDR_W)
  ) u_outreg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .d_addr    (next_addr_w),
    .d_region  (next_region_w),
    .out_valid (out_valid),
    .phys_addr (phys_addr),
    .region    (region)
  );

  always_comb begin
    if (is_mem_w && wide_mode)
      AST_WIDE_MEM_CLEAR: assert (next_addr_w[ADDR_W-1:WIDE_UP_LSB] == '0); // R1
    if (is_io_w && wide_mode)
      AST_WIDE_IO_SET: assert (&next_addr_w[ADDR_W-1:WIDE_UP_LSB]); // R2
    if (is_fw_w)
      AST_FW_TAG: assert (&next_addr_w[ADDR_W-1:FW_TAG_LSB]); // R3
    if (is_mem_w && !wide_mode)
      AST_NARROW_MEM_ZEXT: assert (next_addr_w[ADDR_W-1:NARROW_W] == '0); // R4
    if (is_io_w && !wide_mode)
      AST_NARROW_IO_FILL: assert (next_addr_w[ADDR_W-1:NARROW_W] == {NAR_UP_W{1'b1}}); // R5
    if (is_fw_w && !wide_mode)
      AST_NARROW_FW_LOW: assert (next_addr_w[NARROW_SUB_LSB-1:0] == abs_addr[NARROW_SUB_LSB-1:0]
                                 && next_addr_w[FW_TAG_LSB-1:NARROW_SUB_LSB] == '0); // R6
    if (legacy_mode)
      AST_LEGACY_SAME: assert (next_addr_w == abs_addr && next_region_w == RG_MEM); // R7
  end

  logic [FW_TAG_W-1:0] unused_tag_w;
  assign unused_tag_w = '0;

endmodule

// File: tb/abs_map_top_tb_top.sv
`timescale 1ns/1ps
module abs_map_top_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [63:0] abs_addr;
  logic        wide_mode;
  logic        legacy_mode;
  logic        out_valid;
  logic [63:0] phys_addr;
  logic [1:0]  region;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic        m_valid;
  logic [63:0] m_addr;
  logic [1:0]  m_region;

  always #4 clk = ~clk;

  abs_map_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .abs_addr(abs_addr),
    .wide_mode(wide_mode), .legacy_mode(legacy_mode),
    .out_valid(out_valid), .phys_addr(phys_addr), .region(region)
  );

  // Behavioural reference: literal bit fields taken from the requirements.
  function automatic void ref_map(input logic [63:0] a, input logic w, input logic l,
                                  output logic [63:0] pa, output logic [1:0] rg);
    if (l) begin
      pa = a; rg = 2'd0;                                  // R7
    end else if (w) begin
      if (a[61:58] != 4'hF) begin pa = {2'b00, a[61:0]}; rg = 2'd0; end        // R1
      else if (a[57:54] != 4'h0) begin pa = {2'b11, a[61:0]}; rg = 2'd1; end   // R2
      else begin pa = {4'hF, 6'h0, a[53:0]}; rg = 2'd2; end                    // R3
    end else begin
      if (a[31:28] != 4'hF) begin pa = {32'h0, a[31:0]}; rg = 2'd0; end        // R4
      else if (a[27:24] != 4'h0) begin pa = {32'hFFFF_FFFF, a[31:0]}; rg = 2'd1; end // R5
      else begin pa = {4'hF, 36'h0, a[23:0]}; rg = 2'd2; end                   // R6
    end
  endfunction

  function automatic string tag_of(input logic v, input logic r, input logic w,
                                   input logic l, input logic [1:0] rg);
    if (r) return "R9";
    if (!v) return "R8";
    if (l) return "R7";
    if (w) return (rg == 2'd0) ? "R1" : (rg == 2'd1) ? "R2" : "R3";
    return (rg == 2'd0) ? "R4" : (rg == 2'd1) ? "R5" : "R6";
  endfunction

  task automatic step(input logic v, input logic [63:0] a, input logic w,
                      input logic l, input logic r);
    logic [63:0] pa;
    logic [1:0]  rg;
    string       tg;
    in_valid = v; abs_addr = a; wide_mode = w; legacy_mode = l; rst = r;
    ref_map(a, w, l, pa, rg);
    tg = tag_of(v, r, w, l, rg);
    @(posedge clk);
    if (r) begin
      m_valid = 1'b0; m_addr = '0; m_region = 2'd0;
    end else begin
      m_valid = v;
      if (v) begin m_addr = pa; m_region = rg; end
    end
    @(negedge clk);
    n_vec++;
    if (out_valid !== m_valid || phys_addr !== m_addr || region !== m_region) begin
      n_fail++;
      $display("FAIL %s: got v=%0b pa=%h rg=%0d, expected v=%0b pa=%h rg=%0d",
               tg, out_valid, phys_addr, region, m_valid, m_addr, m_region);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    in_valid = 0; abs_addr = '0; wide_mode = 0; legacy_mode = 0; rst = 1;
    m_valid = 0; m_addr = '0; m_region = 0;
    @(negedge clk);
    // R9: reset state
    step(1'b0, 64'h0, 1'b0, 1'b0, 1'b1);
    // R1 wide memory, including top bits set in input
    step(1, 64'hC123_4567_89AB_CDEF, 1, 0, 0);
    step(1, 64'h3BFF_FFFF_FFFF_FFFF, 1, 0, 0);
    // R2 wide I/O, sub field minimum and maximum
    step(1, 64'h3C40_0000_0000_1234, 1, 0, 0);
    step(1, 64'hBFC0_0000_0000_0000, 1, 0, 0);
    // R3 wide firmware
    step(1, 64'h3C3F_FFFF_FFFF_FFFF, 1, 0, 0);
    step(1, 64'hFC00_0000_0000_0001, 1, 0, 0);
    // R4 narrow memory, upper input ignored
    step(1, 64'hFFFF_FFFF_EFFF_FFFF, 0, 0, 0);
    step(1, 64'h1234_5678_0000_0010, 0, 0, 0);
    // R5 narrow I/O
    step(1, 64'h0000_0000_F100_0000, 0, 0, 0);
    step(1, 64'hAAAA_AAAA_FF12_3456, 0, 0, 0);
    // R6 narrow firmware
    step(1, 64'h5555_5555_F0AB_CDEF, 0, 0, 0);
    step(1, 64'h0000_0000_F000_0000, 0, 0, 0);
    // R7 legacy overrides both modes
    step(1, 64'h3C00_0000_0000_0042, 1, 1, 0);
    step(1, 64'hFFFF_FFFF_F100_0000, 0, 1, 0);
    step(1, 64'hFFC0_0000_0000_0000, 1, 1, 0);
    // R8 idle cycles hold, with changing inputs
    step(0, 64'h3C00_0000_0000_0000, 1, 0, 0);
    step(0, 64'h0, 0, 1, 0);
    step(1, 64'h0000_0000_F800_0001, 0, 0, 0);
    // R9 reset dominates a valid input, then idle holds zero
    step(1, 64'h3C40_0000_0000_0001, 1, 0, 1);
    step(0, 64'h3C40_0000_0000_0001, 1, 0, 0);
    // Mixed patterns with biased selector fields
    for (int i = 0; i < 400; i++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) a[61:58] = 4'hF;
      if ($urandom_range(0, 1) == 1) a[31:28] = 4'hF;
      if ($urandom_range(0, 2) == 0) a[57:54] = 4'h0;
      if ($urandom_range(0, 2) == 0) a[27:24] = 4'h0;
      step($urandom_range(0, 3) != 0, a, $urandom_range(0, 1) == 1,
           $urandom_range(0, 5) == 0, $urandom_range(0, 40) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule